// File: doc/BRIEF.md
# Serial Bank-Register Write Loader

This block sits on the CPU write path of a bank-switching controller. Any CPU write to the upper half of the 16-bit address space goes to one hidden serial port. Each write carries a single data bit. Five data writes, least significant bit first, form a 5-bit value. The value is then committed to one of four internal configuration registers: a control register, two pattern-bank registers and a program-bank register. Only the address of the fifth write chooses the destination. The addresses of the four writes before it play no part.

A write with data bit 7 set is a restart command. It abandons any partial value, so the next write counts as the first bit again. It also forces two mode bits of the control register high. The port filters CPU writes that arrive on back-to-back clock cycles. Read-modify-write instructions produce such pairs, and only the first write of a pair takes effect. The four register values are plain level outputs for the bank decoder downstream. A one-cycle commit pulse and a 2-bit index tell that decoder when a register has changed.

The write strobe acts as a valid signal with no ready. The CPU cannot be stalled, so there is no back-pressure. A write is either taken in its own cycle or dropped by the rules below.

Top module: `serial_bank_loader`

## Requirements
- R1: A write is seen only when `wr_en` is 1 and `addr[15]` is 1. Writes with `addr[15]`=0 have no effect on any output or on the progress of a partial value. Data bits 6:1 are ignored.
- R2: A seen write with `wdata[7]`=0 shifts `wdata[0]` in as the next bit. The first bit becomes bit 0 of the value and the fifth bit becomes bit 4.
- R3: The fifth data write commits the value to the register given by its `addr[14:13]`: 00 control, 01 pattern bank 0, 10 pattern bank 1, 11 program bank. The addresses of the first four writes are ignored.
- R4: After a commit, the next data write is the first bit of a new value.
- R5: A seen write with `wdata[7]`=1 discards partial progress and ignores `wdata[0]`. It sets control bits 3:2 to 1 and leaves every other register bit unchanged.
- R6: A write in the clock cycle right after an accepted write is dropped entirely, whether it is a data write or a restart. Writes two or more cycles apart are all accepted.
- R7: After reset, control is 5'b01100, the other three registers are 0 and `commit_pulse` is 0.
- R8: `commit_pulse` is 1 for exactly the one cycle after the clock edge that takes the fifth write, with `commit_idx` equal to that write's `addr[14:13]`. At all other times it is 0.
- R9: Register outputs change only on the clock edge that takes an accepted write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | CPU write strobe (valid, no ready) |
| addr | input | 16 | CPU write address |
| wdata | input | 8 | CPU write data byte |
| ctrl_q | output | 5 | Control register |
| bank0_q | output | 5 | Pattern bank register 0 |
| bank1_q | output | 5 | Pattern bank register 1 |
| prog_q | output | 5 | Program bank register |
| commit_pulse | output | 1 | One-cycle pulse after a register commit |
| commit_idx | output | 2 | Index of the register just committed |

## Verification
The bound assertions check several properties on every cycle:
- No two accepted writes fall on adjacent cycles.
- The bit counter stays within its range.
- Registers hold still unless a write was accepted.
- A restart sets the two control bits without touching the other registers.
- A fifth write is followed by the pulse and the correct index.

Only the bench scenarios can show the assembled values. These include LSB-first ordering over every value, routing by the last address alone, and realignment after a restart. They also show which write of a back-to-back pair survives, and that low-address writes leave a partial value intact.

// File: rtl/sbl_pkg.sv
package sbl_pkg;
  localparam int REG_W  = 5;
  localparam int N_REGS = 4;
  localparam int IDX_W  = $clog2(N_REGS);
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  localparam int CNT_W  = $clog2(REG_W);

  typedef enum logic [IDX_W-1:0] {
    SEL_CTRL  = 2'd0,
    SEL_BANK0 = 2'd1,
    SEL_BANK1 = 2'd2,
    SEL_PROG  = 2'd3
  } reg_sel_e;

  localparam logic [REG_W-1:0] CTRL_INIT  = 5'b01100;
  localparam logic [REG_W-1:0] CTRL_FORCE = 5'b01100;
endpackage

// File: rtl/sbl_write_filter.sv
module sbl_write_filter (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic addr_hi,
  output logic accept
);
  logic hit;
  logic took_last;

  assign hit    = wr_en && addr_hi;
  assign accept = hit && !took_last;

  always_ff @(posedge clk) begin
    if (!rst_n) took_last <= 1'b0;
    else        took_last <= accept;
  end
endmodule

// File: rtl/sbl_shift_assembler.sv
module sbl_shift_assembler #(
  parameter int REG_W = 5,
  parameter int CNT_W = $clog2(REG_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             restart,
  input  logic             data_bit,
  output logic             done,
  output logic [REG_W-1:0] value,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(REG_W - 1);

  logic [REG_W-1:0] sr;
  logic [CNT_W-1:0] cnt;
  logic             take_bit;

  assign take_bit = accept && !restart;
  assign done     = take_bit && (cnt == LAST);
  assign value    = {data_bit, sr[REG_W-1:1]};
  assign count    = cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr  <= '0;
      cnt <= '0;
    end else if (accept && restart) begin
      sr  <= '0;
      cnt <= '0;
    end else if (done) begin
      sr  <= '0;
      cnt <= '0;
    end else if (take_bit) begin
      sr  <= value;
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/sbl_reg_bank.sv
module sbl_reg_bank #(
  parameter int               REG_W      = 5,
  parameter int               N_REGS     = 4,
  parameter int               IDX_W      = $clog2(N_REGS),
  parameter logic [REG_W-1:0] CTRL_INIT  = 5'b01100,
  parameter logic [REG_W-1:0] CTRL_FORCE = 5'b01100
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_stb,
  input  logic [IDX_W-1:0]             wr_sel,
  input  logic [REG_W-1:0]             wr_val,
  input  logic                         force_set,
  output logic [N_REGS-1:0][REG_W-1:0] regs,
  output logic                         pulse,
  output logic [IDX_W-1:0]             pulse_idx
);
  for (genvar g = 0; g < N_REGS; g++) begin : g_reg
    logic hit_g;
    assign hit_g = wr_stb && (wr_sel == IDX_W'(g));
    if (g == 0) begin : g_ctrl
      always_ff @(posedge clk) begin
        if (!rst_n)         regs[g] <= CTRL_INIT;
        else if (hit_g)     regs[g] <= wr_val;
        else if (force_set) regs[g] <= regs[g] | CTRL_FORCE;
      end
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (!rst_n)     regs[g] <= '0;
        else if (hit_g) regs[g] <= wr_val;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pulse     <= 1'b0;
      pulse_idx <= '0;
    end else begin
      pulse <= wr_stb;
      if (wr_stb) pulse_idx <= wr_sel;
    end
  end
endmodule

// File: rtl/serial_bank_loader.sv
module serial_bank_loader
  import sbl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [REG_W-1:0]  ctrl_q,
  output logic [REG_W-1:0]  bank0_q,
  output logic [REG_W-1:0]  bank1_q,
  output logic [REG_W-1:0]  prog_q,
  output logic              commit_pulse,
  output logic [IDX_W-1:0]  commit_idx
);
  localparam int SEL_LO = ADDR_W - 1 - IDX_W;

  logic                         acc_w;
  logic                         restart_w;
  logic                         done_w;
  logic [REG_W-1:0]             val_w;
  logic [CNT_W-1:0]             cnt_w;
  logic [IDX_W-1:0]             sel_w;
  logic [N_REGS-1:0][REG_W-1:0] regs_w;
  logic                         unused_bits;

  assign restart_w   = wdata[DATA_W-1];
  assign sel_w       = addr[ADDR_W-2:SEL_LO];
  assign unused_bits = ^{wdata[DATA_W-2:1], addr[SEL_LO-1:0]};

  sbl_write_filter u_filter (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .addr_hi (addr[ADDR_W-1]),
    .accept  (acc_w)
  );

  sbl_shift_assembler #(.REG_W(REG_W), .CNT_W(CNT_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (acc_w),
    .restart  (restart_w),
    .data_bit (wdata[0]),
    .done     (done_w),
    .value    (val_w),
    .count    (cnt_w)
  );

  sbl_reg_bank #(
    .REG_W(REG_W), .N_REGS(N_REGS), .IDX_W(IDX_W),
    .CTRL_INIT(CTRL_INIT), .CTRL_FORCE(CTRL_FORCE)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_stb    (done_w),
    .wr_sel    (sel_w),
    .wr_val    (val_w),
    .force_set (acc_w && restart_w),
    .regs      (regs_w),
    .pulse     (commit_pulse),
    .pulse_idx (commit_idx)
  );

  assign ctrl_q  = regs_w[SEL_CTRL];
  assign bank0_q = regs_w[SEL_BANK0];
  assign bank1_q = regs_w[SEL_BANK1];
  assign prog_q  = regs_w[SEL_PROG];
endmodule

// File: rtl/sbl_checker.sv
module sbl_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       accept,
  input logic       restart,
  input logic [2:0] cnt,
  input logic [1:0] sel,
  input logic [4:0] ctrl_q,
  input logic [4:0] bank0_q,
  input logic [4:0] bank1_q,
  input logic [4:0] prog_q,
  input logic       commit_pulse,
  input logic [1:0] commit_idx
);
  AST_NO_ADJACENT_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !accept); // R6

  AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= 3'd4); // R2

  AST_QUIET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> ($stable(ctrl_q) && $stable(bank0_q) && $stable(bank1_q) && $stable(prog_q))); // R9

  AST_RESTART_FORCES_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && restart) |=> (ctrl_q[3:2] == 2'b11 && $stable(bank0_q) && $stable(bank1_q)
                             && $stable(prog_q) && !commit_pulse)); // R5

  AST_COMMIT_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !restart && cnt == 3'd4) |=> (commit_pulse && commit_idx == $past(sel))); // R3

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    commit_pulse |=> !commit_pulse); // R8
endmodule

bind serial_bank_loader sbl_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .accept       (acc_w),
  .restart      (restart_w),
  .cnt          (cnt_w),
  .sel          (sel_w),
  .ctrl_q       (ctrl_q),
  .bank0_q      (bank0_q),
  .bank1_q      (bank1_q),
  .prog_q       (prog_q),
  .commit_pulse (commit_pulse),
  .commit_idx   (commit_idx)
);

// File: tb/tb_serial_bank_loader.sv
module tb_serial_bank_loader;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [4:0]  ctrl_q, bank0_q, bank1_q, prog_q;
  logic        commit_pulse;
  logic [1:0]  commit_idx;

  int total = 0;
  int bad = 0;
  logic [4:0] m_reg [4];

  always #5 clk = ~clk;

  serial_bank_loader dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .ctrl_q(ctrl_q), .bank0_q(bank0_q), .bank1_q(bank1_q), .prog_q(prog_q),
    .commit_pulse(commit_pulse), .commit_idx(commit_idx)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [19:0] model_all();
    return {m_reg[0], m_reg[1], m_reg[2], m_reg[3]};
  endfunction

  function automatic logic [19:0] dut_all();
    return {ctrl_q, bank0_q, bank1_q, prog_q};
  endfunction

  // one write cycle, then the strobe drops (next put leaves one idle cycle)
  task automatic put(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; addr = '0; wdata = '0;
  endtask

  // writes on consecutive cycles
  task automatic burst3(input logic [7:0] d0, input logic [7:0] d1, input logic [7:0] d2);
    @(negedge clk);
    wr_en = 1'b1; addr = 16'h8000; wdata = d0;
    @(negedge clk);
    wdata = d1;
    @(negedge clk);
    wdata = d2;
    @(negedge clk);
    wr_en = 1'b0; addr = '0; wdata = '0;
  endtask

  task automatic load(input logic [1:0] sel, input logic [4:0] v, input int seed);
    for (int i = 0; i < 5; i++) begin
      logic [15:0] a;
      if (i == 4) a = {1'b1, sel, 13'(seed * 7)};
      else        a = {1'b1, 2'(seed + i), 13'(i * 333)};
      put(a, {1'b0, 6'(seed + i * 5), v[i]});
    end
    m_reg[sel] = v;
    check("R8 pulse after fifth write", {31'd0, commit_pulse}, 32'd1);
    check("R8 R3 commit index", {30'd0, commit_idx}, {30'd0, sel});
    @(negedge clk);
    check("R8 pulse lasts one cycle", {31'd0, commit_pulse}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    m_reg[0] = 5'b01100; m_reg[1] = '0; m_reg[2] = '0; m_reg[3] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R7 reset registers", {12'd0, dut_all()}, {12'd0, model_all()});
    check("R7 reset pulse", {31'd0, commit_pulse}, 32'd0);

    // exhaustive sweep: every value into every register, varied early addresses
    for (int s = 0; s < 4; s++) begin
      for (int v = 0; v < 32; v++) begin
        load(2'(s), 5'(v), v + s);
        check("R2 R3 R4 sweep value", {12'd0, dut_all()}, {12'd0, model_all()});
      end
    end

    // R5: restart mid-sequence
    load(2'd0, 5'b10001, 3);
    put(16'hA000, 8'h01);
    put(16'hC000, 8'h00);
    put(16'hFFFF, 8'h81);
    m_reg[0] = m_reg[0] | 5'b01100;
    check("R5 restart sets ctrl bits 3:2 only", {12'd0, dut_all()}, {12'd0, model_all()});
    check("R5 restart gives no pulse", {31'd0, commit_pulse}, 32'd0);
    load(2'd3, 5'b10101, 9);
    check("R5 R4 restart realigns", {27'd0, prog_q}, 32'h15);

    // R1: low-address writes and junk bits ignored
    load(2'd0, 5'b00000, 1);
    put(16'hE000, 8'h01);
    put(16'h7FFF, 8'h80);
    put(16'h6000, 8'h01);
    check("R1 low-address restart ignored", {27'd0, ctrl_q}, 32'h0);
    @(negedge clk);
    wr_en = 1'b0; addr = 16'hE000; wdata = 8'h80;
    @(negedge clk);
    wdata = '0; addr = '0;
    check("R1 strobe low ignored", {27'd0, ctrl_q}, 32'h0);
    put(16'hE000, 8'h7E);
    put(16'hE000, 8'h01);
    put(16'hE000, 8'h00);
    put(16'hE000, 8'h7F);
    m_reg[3] = 5'b10101;
    check("R1 partial value kept across ignored writes", {27'd0, prog_q}, 32'h15);

    // R6: restart then immediate data write; second dropped
    load(2'd0, 5'b00011, 2);
    burst3(8'hFF, 8'h00, 8'h00);
    // accepted: FF (restart), 00 is dropped, third 00 accepted as bit0
    m_reg[0] = m_reg[0] | 5'b01100;
    check("R6 restart pair effect", {27'd0, ctrl_q}, {27'd0, m_reg[0]});
    put(16'hC000, 8'h01);
    put(16'hC000, 8'h00);
    put(16'hC000, 8'h01);
    put(16'hC000, 8'h00);
    m_reg[2] = 5'b01010;
    check("R6 dropped write not counted", {27'd0, bank1_q}, 32'h0A);

    // R6: data triple, middle dropped
    burst3(8'h01, 8'h00, 8'h01);
    put(16'hA000, 8'h00);
    put(16'hA000, 8'h01);
    put(16'hA000, 8'h01);
    m_reg[1] = 5'b11011;
    check("R6 middle of burst dropped", {27'd0, bank0_q}, 32'h1B);

    // R6: restart dropped when right after an accepted data write
    burst3(8'h00, 8'h80, 8'h01);
    put(16'h8000, 8'h01);
    put(16'h8000, 8'h00);
    put(16'hE000, 8'h01);
    m_reg[3] = 5'b10110;
    check("R6 adjacent restart dropped", {12'd0, dut_all()}, {12'd0, model_all()});

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule